// File: doc/BRIEF.md
# Audio Receive Sample Buffer

This block sits between a serial digital audio receiver and a processor read port. Each sample the receiver delivers is 24 bits wide, comes with a flag that marks the left channel, and is written into an eight-entry circular store. The processor sees the oldest stored sample on `rd_data_o` at all times. Pulsing `rd_i` consumes that sample at the next clock edge.

A small set of control inputs sets how the buffer behaves. One input turns the input path off, so that arriving samples are discarded. Another forces reads to return zero. A reset input trims the store down to exactly one sample, which is the most recently accepted one. A two-bit select picks the occupancy at which the buffer counts as full. An auto-sync enable realigns the store to a channel-pair boundary after a trim.

When the occupancy reaches the selected threshold, the block raises a full interrupt and a DMA receive request. If a sample arrives while all entries are occupied, that sample is dropped and a sticky overflow flag is set. The flag stays set until the next trim.

Top module: `audio_rx_fifo`

## Requirements
- R1: After `rst_ni` is released, `level_o`, `full_irq_o`, `dma_req_o`, `overflow_o` and `rd_data_o` are all zero.
- R2: Accepted samples leave in arrival order. `rd_data_o` shows the oldest stored sample in the same cycle, and a clock edge with `rd_i` high removes it.
- R3: `full_irq_o` is high exactly when `level_o` is at least the selected threshold. For `cfg_full_sel_i` values 0, 1, 2 and 3 the thresholds are 1, 2, 3 and 6.
- R4: `dma_req_o` equals `full_irq_o` in every cycle.
- R5: While `cfg_off_i` is high, samples on `in_valid_i` are discarded. They change neither `level_o` nor `overflow_o`.
- R6: While `cfg_rd_zero_i` is high, `rd_data_o` is zero. A read still removes the oldest sample.
- R7: A clock edge with `cfg_fifo_rst_i` high leaves `level_o` at 1 and clears `overflow_o`. The remaining sample is the last one accepted, or zero if none was accepted since `rst_ni`. Input samples and reads in that cycle are ignored.
- R8: A sample that arrives while `level_o` equals 8 is dropped, and `overflow_o` then stays high until a trim. `level_o` never exceeds 8.
- R9: A read while `level_o` is 0 gives `rd_data_o` = 0 and leaves `level_o` at 0.
- R10: If a trim occurs with `cfg_autosync_i` high, the first following sample that has `in_left_i` high replaces the whole contents, leaving `level_o` = 1 with that sample at the head. Samples with `in_left_i` low are stored normally until then. Without auto-sync, no realignment occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_rd_zero_i | input | 1 | Reads return zero |
| cfg_off_i | input | 1 | Discard incoming samples |
| cfg_fifo_rst_i | input | 1 | Trim the store to one sample |
| cfg_full_sel_i | input | 2 | Full threshold select (1/2/3/6) |
| cfg_autosync_i | input | 1 | Realign to a left sample after a trim |
| in_valid_i | input | 1 | Sample strobe from the receiver |
| in_left_i | input | 1 | Sample belongs to the left channel |
| in_data_i | input | 24 | Sample value |
| rd_i | input | 1 | Consume the head sample |
| rd_data_o | output | 24 | Head sample, or zero |
| level_o | output | 4 | Stored sample count |
| full_irq_o | output | 1 | Full interrupt |
| dma_req_o | output | 1 | DMA receive request |
| overflow_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its defaults: a depth of 8, a width of 24, and thresholds of 1, 2, 3 and 6. At this depth every occupancy from empty to full, plus one dropped sample, can be swept under each of the four threshold selects. Each pass also wraps the pointers. Each pass ends with a drain and a trim, which exercises the one-sample state after both full and empty histories. Separate sequences cover the off, read-zero and auto-sync cases.

// File: rtl/audio_rx_fifo_pkg.sv
`timescale 1ns/1ps
package audio_rx_fifo_pkg;
  typedef enum logic [1:0] {
    THR_SEL_A = 2'd0,
    THR_SEL_B = 2'd1,
    THR_SEL_C = 2'd2,
    THR_SEL_D = 2'd3
  } thr_sel_e;

  typedef struct packed {
    logic     rd_zero;
    logic     off;
    logic     fifo_rst;
    thr_sel_e thr_sel;
    logic     autosync;
  } rx_cfg_t;
endpackage

// File: rtl/audio_rx_fifo_store.sv
`timescale 1ns/1ps
module audio_rx_fifo_store #(
  parameter int unsigned DW    = 24,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(g)) mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/audio_rx_fifo_ctrl.sv
`timescale 1ns/1ps
module audio_rx_fifo_ctrl
  import audio_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  rx_cfg_t       cfg_i,
  input  logic          in_valid_i,
  input  logic          in_left_i,
  input  logic          rd_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [CW-1:0] level_o,
  output logic          overflow_o
);
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q, sync_q;
  logic          full, empty, in_ok, realign, push, pop, drop;

  always_comb begin
    full    = cnt_q == CW'(DEPTH);
    empty   = cnt_q == '0;
    in_ok   = in_valid_i && !cfg_i.off && !cfg_i.fifo_rst;
    // pending sync: a left sample restarts the store at a pair boundary
    realign = in_ok && sync_q && in_left_i;
    push    = in_ok && !realign && !full;
    drop    = in_ok && !realign && full;
    pop     = rd_i && !empty && !cfg_i.fifo_rst && !realign;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
      sync_q   <= 1'b0;
    end else if (cfg_i.fifo_rst) begin
      rd_ptr_q <= wr_ptr_q - AW'(1);
      cnt_q    <= CW'(1);
      ovf_q    <= 1'b0;
      sync_q   <= cfg_i.autosync;
    end else if (realign) begin
      rd_ptr_q <= wr_ptr_q;
      wr_ptr_q <= wr_ptr_q + AW'(1);
      cnt_q    <= CW'(1);
      sync_q   <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_q + AW'(push);
      rd_ptr_q <= rd_ptr_q + AW'(pop);
      cnt_q    <= cnt_q + CW'(push) - CW'(pop);
      if (drop) ovf_q <= 1'b1;
      if (!cfg_i.autosync) sync_q <= 1'b0;
    end
  end

  assign wr_en_o    = push || realign;
  assign wr_addr_o  = wr_ptr_q;
  assign rd_addr_o  = rd_ptr_q;
  assign level_o    = cnt_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/audio_rx_fifo_thresh.sv
`timescale 1ns/1ps
module audio_rx_fifo_thresh
  import audio_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned THR_A = 1,
  parameter int unsigned THR_B = 2,
  parameter int unsigned THR_C = 3,
  parameter int unsigned THR_D = 6,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  thr_sel_e      sel_i,
  input  logic [CW-1:0] level_i,
  output logic          hit_o
);
  logic [CW-1:0] limit;

  always_comb begin
    unique case (sel_i)
      THR_SEL_A: limit = CW'(THR_A);
      THR_SEL_B: limit = CW'(THR_B);
      THR_SEL_C: limit = CW'(THR_C);
      default:   limit = CW'(THR_D);
    endcase
    hit_o = level_i >= limit;
  end
endmodule

// File: rtl/audio_rx_fifo.sv
`timescale 1ns/1ps
module audio_rx_fifo
  import audio_rx_fifo_pkg::*;
#(
  parameter int unsigned DW    = 24,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned THR_A = 1,
  parameter int unsigned THR_B = 2,
  parameter int unsigned THR_C = 3,
  parameter int unsigned THR_D = 6,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_rd_zero_i,
  input  logic          cfg_off_i,
  input  logic          cfg_fifo_rst_i,
  input  logic [1:0]    cfg_full_sel_i,
  input  logic          cfg_autosync_i,
  input  logic          in_valid_i,
  input  logic          in_left_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] level_o,
  output logic          full_irq_o,
  output logic          dma_req_o,
  output logic          overflow_o
);
  rx_cfg_t       cfg;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] head;
  logic          hit;

  assign cfg = '{rd_zero:  cfg_rd_zero_i,
                 off:      cfg_off_i,
                 fifo_rst: cfg_fifo_rst_i,
                 thr_sel:  thr_sel_e'(cfg_full_sel_i),
                 autosync: cfg_autosync_i};

  audio_rx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni,
    .cfg_i      (cfg),
    .in_valid_i, .in_left_i, .rd_i,
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .rd_addr_o  (rd_addr),
    .level_o,
    .overflow_o
  );

  audio_rx_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (in_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (head)
  );

  audio_rx_fifo_thresh #(
    .DEPTH(DEPTH), .THR_A(THR_A), .THR_B(THR_B), .THR_C(THR_C), .THR_D(THR_D)
  ) u_thresh (
    .sel_i   (cfg.thr_sel),
    .level_i (level_o),
    .hit_o   (hit)
  );

  assign rd_data_o  = (cfg_rd_zero_i || level_o == '0) ? '0 : head;
  assign full_irq_o = hit;
  assign dma_req_o  = hit;
endmodule

// File: rtl/audio_rx_fifo_chk.sv
`timescale 1ns/1ps
module audio_rx_fifo_chk #(
  parameter int unsigned DW    = 24,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned THR_D = 6,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_rd_zero_i,
  input logic          cfg_off_i,
  input logic          cfg_fifo_rst_i,
  input logic [1:0]    cfg_full_sel_i,
  input logic          rd_i,
  input logic [DW-1:0] rd_data_o,
  input logic [CW-1:0] level_o,
  input logic          full_irq_o,
  input logic          dma_req_o,
  input logic          overflow_o
);
  a_r3_sel_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_full_sel_i == 2'd0 |-> full_irq_o == (level_o != '0));
  a_r3_sel_six: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_full_sel_i == 2'd3 |-> full_irq_o == (level_o >= CW'(THR_D)));
  a_r4_dma_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o == full_irq_o);
  a_r5_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_off_i && !rd_i && !cfg_fifo_rst_i |=> $stable(level_o) && $stable(overflow_o));
  a_r6_rd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rd_zero_i |-> rd_data_o == '0);
  a_r7_trim_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_fifo_rst_i |=> level_o == CW'(1) && !overflow_o);
  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !cfg_fifo_rst_i |=> overflow_o);
  a_r8_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH));
  a_r9_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o == '0 |-> rd_data_o == '0);
endmodule

bind audio_rx_fifo audio_rx_fifo_chk #(.DW(DW), .DEPTH(DEPTH), .THR_D(THR_D)) u_chk (
  .clk_i, .rst_ni, .cfg_rd_zero_i, .cfg_off_i, .cfg_fifo_rst_i, .cfg_full_sel_i,
  .rd_i, .rd_data_o, .level_o, .full_irq_o, .dma_req_o, .overflow_o
);

// File: tb/audio_rx_fifo_tb.sv
`timescale 1ns/1ps
module audio_rx_fifo_tb;
  localparam int DW = 24;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_rd_zero = 0, cfg_off = 0, cfg_frst = 0, cfg_autosync = 0;
  logic [1:0] cfg_sel = 0;
  logic in_valid = 0, in_left = 0, rd = 0;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] rd_data;
  logic [3:0] level;
  logic full_irq, dma_req, overflow;

  int checks = 0, errors = 0;
  int q[$];
  int last_wr = 0;
  bit ovf_m = 0, sync_m = 0;

  always #2.5 clk = ~clk;

  audio_rx_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_rd_zero_i(cfg_rd_zero), .cfg_off_i(cfg_off), .cfg_fifo_rst_i(cfg_frst),
    .cfg_full_sel_i(cfg_sel), .cfg_autosync_i(cfg_autosync),
    .in_valid_i(in_valid), .in_left_i(in_left), .in_data_i(in_data), .rd_i(rd),
    .rd_data_o(rd_data), .level_o(level), .full_irq_o(full_irq),
    .dma_req_o(dma_req), .overflow_o(overflow)
  );

  function automatic int thr(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 3;
      default: return 6;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_state(input string req);
    int exp_head;
    #0.5;
    exp_head = (cfg_rd_zero || q.size() == 0) ? 0 : q[0];
    check({req, " level"}, level, q.size());
    check({req, " overflow"}, overflow, ovf_m);
    check({req, " head"}, rd_data, exp_head);
    check({req, " full"}, full_irq, q.size() >= thr(cfg_sel));
    check({req, " dma"}, dma_req, q.size() >= thr(cfg_sel));
  endtask

  task automatic push(input int d, input bit left);
    in_valid = 1; in_data = DW'(d); in_left = left;
    tick();
    in_valid = 0; in_left = 0;
    if (!cfg_off) begin
      if (sync_m && left) begin
        q = {d}; last_wr = d; sync_m = 0;
      end else if (q.size() < DEPTH) begin
        q.push_back(d); last_wr = d;
      end else ovf_m = 1;
    end
  endtask

  task automatic pop();
    rd = 1;
    tick();
    rd = 0;
    if (q.size() != 0) void'(q.pop_front());
  endtask

  task automatic trim();
    cfg_frst = 1;
    tick();
    cfg_frst = 0;
    q = {last_wr}; ovf_m = 0; sync_m = cfg_autosync;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    check_state("R1 reset");
    // R7 trim right after reset: remaining sample is zero
    trim();
    check_state("R7 trim from empty");
    pop();
    check_state("R9 drained");
    // R9 read on empty
    pop();
    check_state("R9 empty read");

    // R3 R4 R8 R2 R7: sweep every threshold select and every level
    for (int s = 0; s < 4; s++) begin
      cfg_sel = 2'(s);
      #0.5;
      for (int k = 0; k < DEPTH; k++) begin
        check_state("R3 R4 sweep");
        push((s << 16) | (k * 32'h111 + 1), k[0]);
      end
      check_state("R3 R4 at full");
      push(32'hABCDEF, 1'b0);
      check_state("R8 dropped at full");
      for (int k = 0; k < DEPTH; k++) begin
        check_state("R2 drain order");
        pop();
      end
      check_state("R8 sticky after drain");
      trim();
      check_state("R7 trim keeps last accepted");
      pop();
    end

    // R5 off mode
    cfg_sel = 0;
    cfg_off = 1;
    for (int k = 0; k < 3; k++) push(32'h500 + k, 1'b1);
    check_state("R5 off discards");
    cfg_off = 0;

    // R6 read-zero
    push(32'h600001, 1'b1);
    push(32'h600002, 1'b0);
    cfg_rd_zero = 1;
    check_state("R6 zero head");
    pop();
    check_state("R6 read consumes");
    cfg_rd_zero = 0;
    check_state("R6 normal head");
    pop();

    // R7 trim ignores concurrent input and read
    push(32'h700001, 1'b1);
    push(32'h700002, 1'b0);
    in_valid = 1; in_data = 24'h7FFFFF; rd = 1;
    trim();
    in_valid = 0; rd = 0;
    check_state("R7 trim ignores inputs");
    pop();

    // R10 auto-sync realign
    cfg_autosync = 1;
    push(32'hA00001, 1'b1);
    trim();
    check_state("R10 after trim");
    push(32'hA00002, 1'b0);
    check_state("R10 right kept while pending");
    push(32'hA00003, 1'b1);
    check_state("R10 realigned on left");
    push(32'hA00004, 1'b0);
    push(32'hA00005, 1'b1);
    check_state("R10 no second realign");
    pop(); pop(); pop();
    check_state("R10 drained");

    // R10 without auto-sync no realign
    cfg_autosync = 0;
    push(32'hB00001, 1'b0);
    trim();
    push(32'hB00002, 1'b0);
    push(32'hB00003, 1'b1);
    check_state("R10 off no realign");
    pop(); pop(); pop();
    check_state("R2 final empty");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule